// File: doc/BRIEF.md
# One-Time-Programmable Word Store Model

This block is a synthesizable, clocked behavioural model of a 64K x 16 one-time-programmable memory. It serves as the target device in test benches for programmer logic. Three active-low controls select the operating mode: a chip select, an output gate and a program strobe. Two level flags join them. One flag reports that the programming supply is raised. The other reports that the high-voltage identifier level sits on address line 9. The data path is split into an input word and an output word, and a qualifier marks when the output would be driven. A parked, high-impedance pin is modelled as qualifier low with the output word held at zero.

The address bus is 16 bits wide. Storage depth is a parameter, and only the low address bits index the array. Every mode decision is taken from the inputs present at a rising clock edge. The output word and its qualifier are registered, so they appear one cycle later. Programming can only clear bits. Each falling edge of the program strobe seen in program mode ANDs the input word into the addressed word. A synchronous erase-all input returns the whole array to all ones, and so does reset. This gives each simulation a blank part to start from.

Top module: `otp_word_store`

## Requirements
- R1: When `ce_n` is 1, `dout_en` is 0 and `dout` is 0 after the next clock edge, whatever `oe_n`, `pgm_n` and `vpp_hi` are. This holds for both the standby case and the program-inhibit case.
- R2: With `ce_n`=0, `oe_n`=0, `pgm_n`=1, `vpp_hi`=0 and `id_hv`=0, the next edge gives `dout_en`=1 and `dout` = the word stored at the low address bits.
- R3: With `ce_n`=0 and `oe_n`=1, and outside program mode, the next edge gives `dout_en`=0 and `dout`=0. This holds at either supply level.
- R4: With `ce_n`=0, `vpp_hi`=1 and `pgm_n` sampled 0 after being sampled 1 on the previous edge, the addressed word becomes old word AND `din`. `oe_n` has no effect on this, and `dout_en` is 0 in this mode.
- R5: Programming never turns a 0 bit into a 1. Bits already cleared stay cleared even when `din` holds ones there.
- R6: With `ce_n`=0, `oe_n`=0, `pgm_n`=1 and `vpp_hi`=1 (verify), the next edge gives `dout_en`=1 and `dout` = the stored word.
- R7: With `id_hv`=1, `ce_n`=0, `oe_n`=0, `pgm_n`=1 and `vpp_hi`=0, the output gives a fixed code. Address bit 0 = 0 gives 0x0020 and address bit 0 = 1 gives 0x008C, and bits 15..8 are always 0. If any address bit above bit 0 is 1, the output is 0x0000 with `dout_en`=1.
- R8: A strobe held low writes only once. A later change of `din` while `pgm_n` stays 0 does not alter the stored word.
- R9: `erase_all`=1 at an edge sets every word to 0xFFFF. It takes priority over a program write in the same cycle.
- R10: While `rst_n` is 0, `dout_en` and `dout` are 0. Reset leaves every word at 0xFFFF.
- R11: A strobe falling edge while `ce_n`=1 (inhibit) does not change the array.
- R12: A strobe falling edge while `vpp_hi`=0 does not change the array, and the outputs are disabled while `pgm_n`=0 with the supply low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset; blanks the array |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply is raised |
| id_hv | input | 1 | Identifier high voltage present on address line 9 |
| erase_all | input | 1 | Synchronous erase of the whole array |
| addr | input | 16 | Word address |
| din | input | 16 | Word to program |
| dout | output | 16 | Read, verify or identifier word; 0 when not driven |
| dout_en | output | 1 | Output would be driven |

## Verification
The hardest case to reach is a strobe held low across several cycles while the input word changes. From the ports alone, a second write looks just like an overwrite, and only a later verify read can tell the two apart. The stimulus programs one word, changes `din` while `pgm_n` is still low, and then verifies. It also programs over partly cleared words to show that AND-only behaviour, and it forces erase and strobe edges into the same cycle to check erase priority.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        OTP_STANDBY,
        OTP_INHIBIT,
        OTP_OUT_OFF,
        OTP_READ,
        OTP_PROGRAM,
        OTP_VERIFY,
        OTP_IDENT
    } otp_mode_e;

    localparam logic [7:0] IDENT_MAKER = 8'h20;
    localparam logic [7:0] IDENT_PART  = 8'h8C;

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
    import otp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      pgm_n,
    input  logic      vpp_hi,
    input  logic      id_hv,
    output otp_mode_e mode
);

    always_comb begin
        if (ce_n) begin
            mode = vpp_hi ? OTP_INHIBIT : OTP_STANDBY;
        end else if (vpp_hi) begin
            if (!pgm_n)      mode = OTP_PROGRAM;
            else if (!oe_n)  mode = OTP_VERIFY;
            else             mode = OTP_OUT_OFF;
        end else begin
            if (oe_n || !pgm_n) mode = OTP_OUT_OFF;
            else if (id_hv)     mode = OTP_IDENT;
            else                mode = OTP_READ;
        end
    end

endmodule

// File: rtl/otp_ident_rom.sv
module otp_ident_rom
    import otp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              sel_part,
    output logic [DATA_W-1:0] code
);

    logic [7:0] low_byte;

    always_comb begin
        low_byte = sel_part ? IDENT_PART : IDENT_MAKER;
    end

    generate
        if (DATA_W > 8) begin : g_pad
            assign code = {{(DATA_W-8){1'b0}}, low_byte};
        end else begin : g_trim
            assign code = low_byte[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              erase,
    output logic [DATA_W-1:0] rd_word
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } arr_t;

    arr_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (erase) begin
            arr_d.mem = '1;
        end else if (wr_en) begin
            arr_d.mem[idx] = arr_q.mem[idx] & wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_q.mem <= '1;
        end else begin
            arr_q <= arr_d;
        end
    end

    assign rd_word = arr_q.mem[idx];

endmodule

// File: rtl/otp_word_store.sv
module otp_word_store
    import otp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic              pgm_q;
        logic              en;
        logic [DATA_W-1:0] word;
    } port_state_t;

    port_state_t st_d, st_q;
    otp_mode_e   mode;
    logic [DATA_W-1:0] ident_word;
    logic [DATA_W-1:0] cell_word;
    logic              wr_en;
    logic              addr_hi_set;

    otp_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_hi (vpp_hi),
        .id_hv  (id_hv),
        .mode   (mode)
    );

    otp_ident_rom #(.DATA_W(DATA_W)) u_ident (
        .sel_part (addr[0]),
        .code     (ident_word)
    );

    otp_cell_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (addr[IDX_W-1:0]),
        .wr_en   (wr_en),
        .wr_data (din),
        .erase   (erase_all),
        .rd_word (cell_word)
    );

    assign addr_hi_set = |addr[ADDR_W-1:1];
    assign wr_en       = (mode == OTP_PROGRAM) && st_q.pgm_q;

    always_comb begin
        st_d       = st_q;
        st_d.pgm_q = pgm_n;
        st_d.en    = 1'b0;
        st_d.word  = '0;
        case (mode)
            OTP_READ, OTP_VERIFY: begin
                st_d.en   = 1'b1;
                st_d.word = cell_word;
            end
            OTP_IDENT: begin
                st_d.en   = 1'b1;
                st_d.word = addr_hi_set ? '0 : ident_word;
            end
            default: begin
                st_d.en   = 1'b0;
                st_d.word = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pgm_q <= 1'b1;
            st_q.en    <= 1'b0;
            st_q.word  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.word;
    assign dout_en = st_q.en;

endmodule

// File: rtl/otp_word_store_chk.sv
module otp_word_store_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              pgm_n,
    input logic              vpp_hi,
    input logic              id_hv,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dout_en && dout == '0));

    a_r3_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && pgm_n) |=> !dout_en);

    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && pgm_n && !vpp_hi && !id_hv) |=> dout_en);

    a_r4_program_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_hi && !pgm_n) |=> !dout_en);

    a_r6_verify_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && pgm_n && vpp_hi) |=> dout_en);

    a_r7_ident_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && pgm_n && !vpp_hi && id_hv) |=> (dout_en && dout[DATA_W-1:8] == '0));

    a_r12_low_supply_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !vpp_hi && !pgm_n) |=> !dout_en);

endmodule

bind otp_word_store otp_word_store_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .pgm_n   (pgm_n),
    .vpp_hi  (vpp_hi),
    .id_hv   (id_hv),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/tb_otp_word_store.sv
`timescale 1ns/1ps
module tb_otp_word_store;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce_n, oe_n, pgm_n, vpp_hi, id_hv, erase_all;
    logic [15:0] addr, din;
    logic [15:0] dout;
    logic        dout_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    otp_word_store dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_hi(vpp_hi), .id_hv(id_hv), .erase_all(erase_all),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    typedef struct packed {
        logic        ce_n;
        logic        oe_n;
        logic        pgm_n;
        logic        vpp;
        logic        id;
        logic [15:0] addr;
        logic [15:0] din;
        logic        exp_en;
        logic [15:0] exp_d;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b1,16'hFFFF,8'd2},  // R2 blank read
        '{1'b1,1'b0,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b0,16'h0000,8'd1},  // R1 standby
        '{1'b0,1'b1,1'b1,1'b0,1'b0,16'h0005,16'h0000,1'b0,16'h0000,8'd3},  // R3 gate closed
        '{1'b0,1'b1,1'b1,1'b1,1'b0,16'h0005,16'h0000,1'b0,16'h0000,8'd3},  // R3 raised supply
        '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h0005,16'hA5F0,1'b0,16'h0000,8'd4},  // R4 program, oe low
        '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h0005,16'h0000,1'b1,16'hA5F0,8'd6},  // R6 verify
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h0005,16'h0FFF,1'b0,16'h0000,8'd4},  // R4 program, oe high
        '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h0005,16'h0000,1'b1,16'h05F0,8'd5},  // R5 AND only
        '{1'b0,1'b1,1'b1,1'b1,1'b0,16'h0006,16'h0000,1'b0,16'h0000,8'd3},  // R3 setup
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h0006,16'h1234,1'b0,16'h0000,8'd4},  // R4 first edge
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h0006,16'h0000,1'b0,16'h0000,8'd8},  // R8 held low
        '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h0006,16'h0000,1'b1,16'h1234,8'd8},  // R8 single write
        '{1'b0,1'b0,1'b1,1'b0,1'b1,16'h0000,16'h0000,1'b1,16'h0020,8'd7},  // R7 maker code
        '{1'b0,1'b0,1'b1,1'b0,1'b1,16'h0001,16'h0000,1'b1,16'h008C,8'd7},  // R7 part code
        '{1'b0,1'b0,1'b1,1'b0,1'b1,16'h0003,16'h0000,1'b1,16'h0000,8'd7},  // R7 upper addr set
        '{1'b1,1'b1,1'b1,1'b1,1'b0,16'h0007,16'h0000,1'b0,16'h0000,8'd1},  // R1 inhibit
        '{1'b1,1'b0,1'b0,1'b1,1'b0,16'h0007,16'h0000,1'b0,16'h0000,8'd11}, // R11 strobe inhibited
        '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0007,16'h0000,1'b1,16'hFFFF,8'd11}, // R11 unchanged
        '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0007,16'h0000,1'b0,16'h0000,8'd12}, // R12 low supply
        '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0007,16'h0000,1'b1,16'hFFFF,8'd12}, // R12 unchanged
        '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0105,16'h0000,1'b1,16'h05F0,8'd2},  // R2 high bits ignored
        '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0006,16'h0000,1'b1,16'h1234,8'd2}   // R2 read back
    };

    task automatic check(input int req, input logic got_en, input logic exp_en,
                         input logic [15:0] got_d, input logic [15:0] exp_d);
        n_checks++;
        if (got_en !== exp_en || got_d !== exp_d) begin
            n_fails++;
            $display("FAIL R%0d: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                     req, got_en, got_d, exp_en, exp_d);
        end
    endtask

    task automatic drive(input logic c, input logic o, input logic p, input logic v,
                         input logic i, input logic e, input logic [15:0] a,
                         input logic [15:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; id_hv = i; erase_all = e;
        addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_read(input logic [15:0] a);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; vpp_hi = 1'b0; id_hv = 1'b0;
        erase_all = 1'b0; addr = '0; din = '0;
        repeat (3) @(posedge clk);
        #1;
        check(10, dout_en, 1'b0, dout, 16'h0000);  // R10 outputs quiet in reset
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            drive(VECS[k].ce_n, VECS[k].oe_n, VECS[k].pgm_n, VECS[k].vpp,
                  VECS[k].id, 1'b0, VECS[k].addr, VECS[k].din);
            check(int'(VECS[k].req), dout_en, VECS[k].exp_en, dout, VECS[k].exp_d);
        end

        // R9: erase restores all ones; output in the erase cycle still shows the old word
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0005, 16'h0000);
        check(9, dout_en, 1'b1, dout, 16'h05F0);
        idle_read(16'h0005);
        check(9, dout_en, 1'b1, dout, 16'hFFFF);
        idle_read(16'h0006);
        check(9, dout_en, 1'b1, dout, 16'hFFFF);

        // R9: erase wins over a strobe edge in the same cycle
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0009, 16'h0000);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0009, 16'h0000);
        idle_read(16'h0009);
        check(9, dout_en, 1'b1, dout, 16'hFFFF);

        // R5: clear more bits on a word, then try to restore them
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0003, 16'h0000);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0003, 16'hF00F);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0003, 16'h0000);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0003, 16'hFFFF);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0003, 16'h0000);
        check(5, dout_en, 1'b1, dout, 16'hF00F);

        // R10: reset mid-run blanks the array again
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(10, dout_en, 1'b0, dout, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        idle_read(16'h0003);
        check(10, dout_en, 1'b1, dout, 16'hFFFF);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule